// File: doc/BRIEF.md
# I2C Host Register Front End

This block is the host-facing half of a byte-level I2C controller. An 8-bit Wishbone slave with eight register offsets takes host accesses and turns them into work for a separate bus engine. A write to the command offset builds a command word and queues it. The word joins the current 7-bit target address to four operation flags: start, read, write and stop. A write to the data offset queues an outgoing byte. Bytes that the engine collects from the bus wait in a receive queue until the host reads them, one per access, from that same data offset.

The engine is attached through three valid/ready channels: commands out, write bytes out, and received bytes in. It also reports a busy level and a one-cycle pulse when a target fails to acknowledge. The host launches a transfer with a burst of writes: target address, then command, then data. It then polls the status offset until the two low bits read zero, and checks there whether the acknowledge was missed. A prescale value for the engine's bit timing is held at offsets 6 and 7. A parameter selects whether it can be programmed or stays fixed at its reset value.

Top module: `i2cHostFront`

## Requirements
- R1: After reset: status reads 0x00, `busAck`, `cmdValid` and `wrValid` are low, `rdReady` is high, and `prescale` equals `PRESCALE_RESET`.
- R2: Each access with `busStb` and `busCyc` both high gets `busAck` high on the next clock edge for exactly one cycle. A strobe without `busCyc` is never acknowledged.
- R3: Offset 2 stores the target address as bits [6:0] of the written byte. It reads back with bit 7 as zero.
- R4: Writing offset 3 queues the word {address[6:0], byte bit4 (stop), bit2 (write), bit1 (read), bit0 (start)}. `cmdValid` rises one clock after the edge that raises `busAck`.
- R5: Command words leave through `cmdValid`/`cmdData` in the order they were written. The head word holds steady until a clock with `cmdReady` high removes it.
- R6: Writing offset 4 queues the byte for the engine. Bytes leave on `wrValid`/`wrData` in write order and are removed on clocks with `wrReady` high.
- R7: `rdReady` is high unless the receive queue holds 32 bytes. Reading offset 4 returns and removes the oldest received byte. A read of offset 4 with the queue empty returns 0x00 and removes nothing.
- R8: Status bit 0 is (engine busy OR command pending). Bit 1 is command pending. Bit 2 is receive data available.
- R9: Status bit 3 is set by an `engMissedAck` pulse. It stays set until the host writes the status offset with bit 3 = 1; writing bit 3 = 0 leaves it set.
- R10: The command and write queues each hold 32 entries. A write to either one while it is full is dropped and sets sticky status bit 4, which clears when the host writes the status offset with bit 4 = 1.
- R11: With a programmable prescale, offsets 6 and 7 hold the low and high bytes of `prescale`. They read back and start at `PRESCALE_RESET`.
- R12: Offsets 1 and 5 read as 0x00, and writes to them change no status, queue or register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| busAdr | input | 3 | Register offset |
| busDatIn | input | 8 | Host write data |
| busDatOut | output | 8 | Host read data, valid with `busAck` |
| busWe | input | 1 | Write enable |
| busStb | input | 1 | Strobe |
| busCyc | input | 1 | Cycle valid |
| busAck | output | 1 | One-cycle acknowledge |
| cmdValid | output | 1 | Command word available |
| cmdData | output | ADDR_BITS+4 | Command word {address, stop, write, read, start} |
| cmdReady | input | 1 | Engine takes the command word |
| wrValid | output | 1 | Write byte available |
| wrData | output | 8 | Write byte |
| wrReady | input | 1 | Engine takes the write byte |
| rdValid | input | 1 | Engine offers a received byte |
| rdData | input | 8 | Received byte |
| rdReady | output | 1 | Receive queue has room |
| engBusy | input | 1 | Engine is working on the bus |
| engMissedAck | input | 1 | One-cycle pulse: target did not acknowledge |
| prescale | output | 16 | Bit-timing divider for the engine |

## Verification
A host read returns its data on the edge that raises `busAck`, and the receive queue pops on that same edge. A host write takes effect one edge later, because the strobe struct between control and datapath is registered. Queued commands, queued bytes, status bits and register contents therefore show up one cycle after the acknowledge. The bench drives inputs on falling edges and samples on falling edges. Its write task returns only after the effect edge has passed, and one scenario samples `cmdValid` at the acknowledge cycle and again one cycle later to pin down that delay. Engine-side pushes, pops and missed-acknowledge pulses each last one clock, and their results are checked on the falling edge that follows.

// File: rtl/i2cHostFrontPkg.sv
package i2cHostFrontPkg;
  timeunit 1ns; timeprecision 100ps;

  localparam logic [2:0] OFS_STATUS = 3'd0;
  localparam logic [2:0] OFS_TARGET = 3'd2;
  localparam logic [2:0] OFS_CMD    = 3'd3;
  localparam logic [2:0] OFS_DATA   = 3'd4;
  localparam logic [2:0] OFS_PRE_LO = 3'd6;
  localparam logic [2:0] OFS_PRE_HI = 3'd7;

  // command byte flag positions (decoded by the engine in this order)
  localparam int FLAG_START = 0;
  localparam int FLAG_READ  = 1;
  localparam int FLAG_WRITE = 2;
  localparam int FLAG_STOP  = 4;

  // status bit positions
  localparam int ST_BUSY  = 0;
  localparam int ST_PEND  = 1;
  localparam int ST_AVAIL = 2;
  localparam int ST_MISS  = 3;
  localparam int ST_OVF   = 4;

  typedef struct packed {
    logic       setTarget;
    logic       pushCmd;
    logic       pushData;
    logic       wrStatus;
    logic       wrPreLo;
    logic       wrPreHi;
    logic [7:0] byteIn;
  } hostStrobes_t;
endpackage

// File: rtl/hostFifo.sv
module hostFifo #(
  parameter int WIDTH  = 8,
  parameter int ADDR_W = 5
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             push,
  input  logic [WIDTH-1:0] din,
  output logic             full,
  input  logic             pop,
  output logic [WIDTH-1:0] dout,
  output logic             empty
);
  timeunit 1ns; timeprecision 100ps;

  localparam int DEPTH = 1 << ADDR_W;

  logic [WIDTH-1:0]  mem [DEPTH];
  logic [ADDR_W-1:0] wrPtr, rdPtr;
  logic [ADDR_W:0]   count;
  logic              doPush, doPop;

  assign full   = (count == (ADDR_W+1)'(DEPTH));
  assign empty  = (count == '0);
  assign doPush = push & ~full;
  assign doPop  = pop & ~empty;
  assign dout   = mem[rdPtr];

  always_ff @(posedge clk) begin
    if (doPush) mem[wrPtr] <= din;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wrPtr <= '0;
      rdPtr <= '0;
      count <= '0;
    end else begin
      if (doPush) wrPtr <= wrPtr + 1'b1;
      if (doPop)  rdPtr <= rdPtr + 1'b1;
      count <= count + (ADDR_W+1)'(doPush) - (ADDR_W+1)'(doPop);
    end
  end

  // R5: the head entry is not disturbed while nobody pops it
  p_head_stable_r5: assert property (@(posedge clk) disable iff (rst)
    (!empty && !pop) |=> $stable(dout));
  // R10: occupancy never exceeds the capacity
  p_count_bound_r10: assert property (@(posedge clk) disable iff (rst)
    count <= (ADDR_W+1)'(DEPTH));
endmodule

// File: rtl/i2cHostCtrl.sv
module i2cHostCtrl
  import i2cHostFrontPkg::*;
(
  input  logic         clk,
  input  logic         rst,
  input  logic [2:0]   busAdr,
  input  logic [7:0]   busDatIn,
  input  logic         busWe,
  input  logic         busStb,
  input  logic         busCyc,
  output logic         busAck,
  output hostStrobes_t strobes,
  output logic         rdReq,
  output logic [2:0]   rdAdr
);
  timeunit 1ns; timeprecision 100ps;

  logic accept, wrAcc;

  assign accept = busStb & busCyc & ~busAck;
  assign wrAcc  = accept & busWe;
  assign rdReq  = accept & ~busWe;
  assign rdAdr  = busAdr;

  always_ff @(posedge clk) begin
    if (rst) begin
      busAck  <= 1'b0;
      strobes <= '0;
    end else begin
      busAck            <= accept;
      strobes.setTarget <= wrAcc & (busAdr == OFS_TARGET);
      strobes.pushCmd   <= wrAcc & (busAdr == OFS_CMD);
      strobes.pushData  <= wrAcc & (busAdr == OFS_DATA);
      strobes.wrStatus  <= wrAcc & (busAdr == OFS_STATUS);
      strobes.wrPreLo   <= wrAcc & (busAdr == OFS_PRE_LO);
      strobes.wrPreHi   <= wrAcc & (busAdr == OFS_PRE_HI);
      strobes.byteIn    <= busDatIn;
    end
  end

  // R2: acknowledge lasts a single cycle
  p_ack_single_r2: assert property (@(posedge clk) disable iff (rst)
    busAck |=> !busAck);
  // R2: acknowledge only follows a full strobe
  p_ack_cause_r2: assert property (@(posedge clk) disable iff (rst)
    busAck |-> $past(busStb && busCyc));
endmodule

// File: rtl/i2cHostData.sv
module i2cHostData
  import i2cHostFrontPkg::*;
#(
  parameter int          ADDR_BITS      = 7,
  parameter int          CMD_FIFO_AW    = 5,
  parameter int          WR_FIFO_AW     = 5,
  parameter int          RD_FIFO_AW     = 5,
  parameter bit          PRESCALE_FIXED = 1'b0,
  parameter logic [15:0] PRESCALE_RESET = 16'h0140
) (
  input  logic                 clk,
  input  logic                 rst,
  input  hostStrobes_t         strobes,
  input  logic                 rdReq,
  input  logic [2:0]           rdAdr,
  output logic [7:0]           busDatOut,
  output logic                 cmdValid,
  output logic [ADDR_BITS+3:0] cmdData,
  input  logic                 cmdReady,
  output logic                 wrValid,
  output logic [7:0]           wrData,
  input  logic                 wrReady,
  input  logic                 rdValid,
  input  logic [7:0]           rdData,
  output logic                 rdReady,
  input  logic                 engBusy,
  input  logic                 engMissedAck,
  output logic [15:0]          prescale
);
  timeunit 1ns; timeprecision 100ps;

  localparam int CMD_W = ADDR_BITS + 4;

  logic [ADDR_BITS-1:0] target;
  logic [CMD_W-1:0]     cmdWord;
  logic                 cmdFull, cmdEmpty, wrFull, wrEmpty, rdFull, rdEmpty;
  logic [7:0]           rdHead, status;
  logic                 missFlag, ovfFlag, rdPop;

  assign cmdWord = {target, strobes.byteIn[FLAG_STOP], strobes.byteIn[FLAG_WRITE],
                    strobes.byteIn[FLAG_READ], strobes.byteIn[FLAG_START]};

  hostFifo #(.WIDTH(CMD_W), .ADDR_W(CMD_FIFO_AW)) u_cmdq (
    .clk(clk), .rst(rst), .push(strobes.pushCmd), .din(cmdWord), .full(cmdFull),
    .pop(cmdReady), .dout(cmdData), .empty(cmdEmpty));

  hostFifo #(.WIDTH(8), .ADDR_W(WR_FIFO_AW)) u_wrq (
    .clk(clk), .rst(rst), .push(strobes.pushData), .din(strobes.byteIn), .full(wrFull),
    .pop(wrReady), .dout(wrData), .empty(wrEmpty));

  assign rdPop = rdReq & (rdAdr == OFS_DATA);

  hostFifo #(.WIDTH(8), .ADDR_W(RD_FIFO_AW)) u_rdq (
    .clk(clk), .rst(rst), .push(rdValid), .din(rdData), .full(rdFull),
    .pop(rdPop), .dout(rdHead), .empty(rdEmpty));

  assign cmdValid = ~cmdEmpty;
  assign wrValid  = ~wrEmpty;
  assign rdReady  = ~rdFull;

  always_comb begin
    status           = '0;
    status[ST_BUSY]  = engBusy | ~cmdEmpty;
    status[ST_PEND]  = ~cmdEmpty;
    status[ST_AVAIL] = ~rdEmpty;
    status[ST_MISS]  = missFlag;
    status[ST_OVF]   = ovfFlag;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      target   <= '0;
      missFlag <= 1'b0;
      ovfFlag  <= 1'b0;
    end else begin
      if (strobes.setTarget) target <= strobes.byteIn[ADDR_BITS-1:0];
      if (engMissedAck) missFlag <= 1'b1;
      else if (strobes.wrStatus && strobes.byteIn[ST_MISS]) missFlag <= 1'b0;
      if ((strobes.pushCmd && cmdFull) || (strobes.pushData && wrFull)) ovfFlag <= 1'b1;
      else if (strobes.wrStatus && strobes.byteIn[ST_OVF]) ovfFlag <= 1'b0;
    end
  end

  generate
    if (PRESCALE_FIXED) begin : g_preFixed
      assign prescale = PRESCALE_RESET;
    end else begin : g_preProg
      always_ff @(posedge clk) begin
        if (rst) prescale <= PRESCALE_RESET;
        else begin
          if (strobes.wrPreLo) prescale[7:0]  <= strobes.byteIn;
          if (strobes.wrPreHi) prescale[15:8] <= strobes.byteIn;
        end
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) busDatOut <= '0;
    else if (rdReq) begin
      case (rdAdr)
        OFS_STATUS: busDatOut <= status;
        OFS_TARGET: busDatOut <= 8'(target);
        OFS_DATA:   busDatOut <= rdEmpty ? 8'h00 : rdHead;
        OFS_PRE_LO: busDatOut <= prescale[7:0];
        OFS_PRE_HI: busDatOut <= prescale[15:8];
        default:    busDatOut <= 8'h00;
      endcase
    end
  end

  // R7: a data read of an empty receive queue yields zero
  p_empty_read_r7: assert property (@(posedge clk) disable iff (rst)
    (rdPop && rdEmpty) |=> (busDatOut == 8'h00));
  // R9: the missed-ack flag holds until explicitly cleared
  p_miss_sticky_r9: assert property (@(posedge clk) disable iff (rst)
    (missFlag && !(strobes.wrStatus && strobes.byteIn[ST_MISS])) |=> missFlag);
  // R10: a write into a full queue raises the overflow flag
  p_no_overflow_r10: assert property (@(posedge clk) disable iff (rst)
    ((strobes.pushData && wrFull) || (strobes.pushCmd && cmdFull)) |=> ovfFlag);
endmodule

// File: rtl/i2cHostFront.sv
module i2cHostFront
  import i2cHostFrontPkg::*;
#(
  parameter int          ADDR_BITS      = 7,
  parameter int          CMD_FIFO_AW    = 5,
  parameter int          WR_FIFO_AW     = 5,
  parameter int          RD_FIFO_AW     = 5,
  parameter bit          PRESCALE_FIXED = 1'b0,
  parameter logic [15:0] PRESCALE_RESET = 16'h0140
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic [2:0]           busAdr,
  input  logic [7:0]           busDatIn,
  output logic [7:0]           busDatOut,
  input  logic                 busWe,
  input  logic                 busStb,
  input  logic                 busCyc,
  output logic                 busAck,
  output logic                 cmdValid,
  output logic [ADDR_BITS+3:0] cmdData,
  input  logic                 cmdReady,
  output logic                 wrValid,
  output logic [7:0]           wrData,
  input  logic                 wrReady,
  input  logic                 rdValid,
  input  logic [7:0]           rdData,
  output logic                 rdReady,
  input  logic                 engBusy,
  input  logic                 engMissedAck,
  output logic [15:0]          prescale
);
  timeunit 1ns; timeprecision 100ps;

  hostStrobes_t strobes;
  logic         rdReq;
  logic [2:0]   rdAdr;

  i2cHostCtrl u_ctrl (
    .clk(clk), .rst(rst), .busAdr(busAdr), .busDatIn(busDatIn), .busWe(busWe),
    .busStb(busStb), .busCyc(busCyc), .busAck(busAck), .strobes(strobes),
    .rdReq(rdReq), .rdAdr(rdAdr));

  i2cHostData #(
    .ADDR_BITS(ADDR_BITS), .CMD_FIFO_AW(CMD_FIFO_AW), .WR_FIFO_AW(WR_FIFO_AW),
    .RD_FIFO_AW(RD_FIFO_AW), .PRESCALE_FIXED(PRESCALE_FIXED),
    .PRESCALE_RESET(PRESCALE_RESET)
  ) u_data (
    .clk(clk), .rst(rst), .strobes(strobes), .rdReq(rdReq), .rdAdr(rdAdr),
    .busDatOut(busDatOut), .cmdValid(cmdValid), .cmdData(cmdData), .cmdReady(cmdReady),
    .wrValid(wrValid), .wrData(wrData), .wrReady(wrReady), .rdValid(rdValid),
    .rdData(rdData), .rdReady(rdReady), .engBusy(engBusy), .engMissedAck(engMissedAck),
    .prescale(prescale));
endmodule

// File: tb/sim_i2cHostFront.sv
module sim_i2cHostFront;
  timeunit 1ns; timeprecision 100ps;

  localparam logic [15:0] PRE_RST = 16'h0140;

  logic        clk = 1'b0, rst = 1'b1;
  logic [2:0]  busAdr = '0;
  logic [7:0]  busDatIn = '0, busDatOut;
  logic        busWe = 0, busStb = 0, busCyc = 0, busAck;
  logic        cmdValid, cmdReady = 0;
  logic [10:0] cmdData;
  logic        wrValid, wrReady = 0;
  logic [7:0]  wrData;
  logic        rdValid = 0, rdReady;
  logic [7:0]  rdData = '0;
  logic        engBusy = 0, engMissedAck = 0;
  logic [15:0] prescale;

  int nChecks = 0, nFails = 0;
  logic ackSeen;

  always #2.5 clk = ~clk;

  i2cHostFront #(.PRESCALE_RESET(PRE_RST)) u0 (.*);

  task automatic check(input string req, input string what, input logic [31:0] act,
                       input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
    end
  endtask

  task automatic busWrite(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk); busAdr = a; busDatIn = d; busWe = 1; busStb = 1; busCyc = 1;
    @(negedge clk); ackSeen = busAck; busStb = 0; busCyc = 0; busWe = 0;
    @(negedge clk);
  endtask

  task automatic busRead(input logic [2:0] a, output logic [7:0] d);
    @(negedge clk); busAdr = a; busWe = 0; busStb = 1; busCyc = 1;
    @(negedge clk); d = busDatOut; ackSeen = busAck; busStb = 0; busCyc = 0;
  endtask

  task automatic expectStatus(input string req, input logic [7:0] exp);
    logic [7:0] v;
    busRead(3'd0, v);
    check(req, "status", v, exp);
  endtask

  task automatic popCmd();
    @(negedge clk); cmdReady = 1; @(negedge clk); cmdReady = 0;
  endtask
  task automatic popWr();
    @(negedge clk); wrReady = 1; @(negedge clk); wrReady = 0;
  endtask
  task automatic pushRd(input logic [7:0] d);
    @(negedge clk); rdValid = 1; rdData = d; @(negedge clk); rdValid = 0;
  endtask

  task automatic t_reset();
    @(negedge clk);
    check("R1", "busAck", busAck, 0);
    check("R1", "cmdValid", cmdValid, 0);
    check("R1", "wrValid", wrValid, 0);
    check("R1", "rdReady", rdReady, 1);
    check("R1", "prescale", prescale, PRE_RST);
    expectStatus("R1", 8'h00);
  endtask

  task automatic t_ack();
    logic [7:0] v;
    @(negedge clk); busAdr = 0; busStb = 1; busCyc = 0; busWe = 0;
    for (int i = 0; i < 3; i++) begin
      @(negedge clk); check("R2", "ack without cyc", busAck, 0);
    end
    busStb = 0;
    busRead(3'd0, v);
    check("R2", "ack on read", ackSeen, 1);
    @(negedge clk); check("R2", "ack drops", busAck, 0);
    busWrite(3'd2, 8'h50);
    check("R2", "ack on write", ackSeen, 1);
  endtask

  task automatic t_target();
    logic [7:0] v;
    busWrite(3'd2, 8'h50); busRead(3'd2, v); check("R3", "target", v, 8'h50);
    busWrite(3'd2, 8'hD1); busRead(3'd2, v); check("R3", "target bit7", v, 8'h51);
    busWrite(3'd2, 8'h50);
  endtask

  task automatic t_cmdTiming();
    @(negedge clk); busAdr = 3; busDatIn = 8'h14; busWe = 1; busStb = 1; busCyc = 1;
    @(negedge clk);
    check("R4", "ack", busAck, 1);
    check("R4", "cmdValid at ack", cmdValid, 0);
    busStb = 0; busCyc = 0; busWe = 0;
    @(negedge clk);
    check("R4", "cmdValid after", cmdValid, 1);
    check("R4", "cmdData", cmdData, 11'h50C);
    expectStatus("R8", 8'h03);
  endtask

  task automatic t_cmdOrder();
    busWrite(3'd2, 8'h51);
    busWrite(3'd3, 8'h03);
    busWrite(3'd3, 8'h12);
    repeat (3) @(negedge clk);
    check("R5", "head held", cmdData, 11'h50C);
    popCmd(); check("R5", "second", cmdData, 11'h513);
    popCmd(); check("R5", "third", cmdData, 11'h51A);
    popCmd(); check("R5", "drained", cmdValid, 0);
    expectStatus("R8", 8'h00);
    engBusy = 1;
    expectStatus("R8", 8'h01);
    engBusy = 0;
  endtask

  task automatic t_wrData();
    busWrite(3'd4, 8'h11); busWrite(3'd4, 8'h22); busWrite(3'd4, 8'h33);
    check("R6", "wrValid", wrValid, 1);
    check("R6", "first", wrData, 8'h11);
    popWr(); check("R6", "second", wrData, 8'h22);
    popWr(); check("R6", "third", wrData, 8'h33);
    popWr(); check("R6", "drained", wrValid, 0);
  endtask

  task automatic t_rdData();
    logic [7:0] v;
    pushRd(8'hAA); pushRd(8'hBB);
    expectStatus("R8", 8'h04);
    busRead(3'd4, v); check("R7", "first", v, 8'hAA);
    busRead(3'd4, v); check("R7", "second", v, 8'hBB);
    busRead(3'd4, v); check("R7", "empty read", v, 8'h00);
    expectStatus("R7", 8'h00);
    for (int i = 0; i < 32; i++) pushRd(8'(8'h40 + i));
    check("R7", "rdReady full", rdReady, 0);
    for (int i = 0; i < 32; i++) begin
      busRead(3'd4, v); check("R7", "fill order", v, 8'(8'h40 + i));
    end
    @(negedge clk); check("R7", "rdReady again", rdReady, 1);
    busRead(3'd4, v); check("R7", "empty after fill", v, 8'h00);
  endtask

  task automatic t_missAck();
    @(negedge clk); engMissedAck = 1; @(negedge clk); engMissedAck = 0;
    expectStatus("R9", 8'h08);
    busWrite(3'd0, 8'h00);
    expectStatus("R9", 8'h08);
    busWrite(3'd0, 8'h08);
    expectStatus("R9", 8'h00);
  endtask

  task automatic t_overflow();
    int n;
    for (int i = 0; i < 33; i++) busWrite(3'd4, 8'(i));
    expectStatus("R10", 8'h10);
    n = 0;
    for (int i = 0; i < 40; i++) begin
      if (wrValid) begin
        check("R10", "kept byte", wrData, 8'(n));
        n++; popWr();
      end
    end
    check("R10", "write queue depth", n, 32);
    busWrite(3'd0, 8'h10);
    expectStatus("R10", 8'h00);
    for (int i = 0; i < 33; i++) busWrite(3'd3, 8'h04);
    expectStatus("R10", 8'h13);
    n = 0;
    for (int i = 0; i < 40; i++) begin
      if (cmdValid) begin n++; popCmd(); end
    end
    check("R10", "command queue depth", n, 32);
    busWrite(3'd0, 8'h10);
    expectStatus("R10", 8'h00);
  endtask

  task automatic t_prescale();
    logic [7:0] v;
    busRead(3'd6, v); check("R11", "reset low", v, PRE_RST[7:0]);
    busRead(3'd7, v); check("R11", "reset high", v, PRE_RST[15:8]);
    busWrite(3'd6, 8'h34); busWrite(3'd7, 8'h12);
    check("R11", "prescale port", prescale, 16'h1234);
    busRead(3'd7, v); check("R11", "readback high", v, 8'h12);
  endtask

  task automatic t_unused();
    logic [7:0] v;
    busWrite(3'd1, 8'hFF); busWrite(3'd5, 8'hFF);
    busRead(3'd1, v); check("R12", "offset 1", v, 8'h00);
    busRead(3'd5, v); check("R12", "offset 5", v, 8'h00);
    expectStatus("R12", 8'h00);
    check("R12", "cmdValid", cmdValid, 0);
    check("R12", "wrValid", wrValid, 0);
    check("R12", "prescale", prescale, 16'h1234);
    busRead(3'd2, v); check("R12", "target kept", v, 8'h51);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst = 0;
    t_reset();
    t_ack();
    t_target();
    t_cmdTiming();
    t_cmdOrder();
    t_wrData();
    t_rdData();
    t_missAck();
    t_overflow();
    t_prescale();
    t_unused();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end

  initial begin
    #500000;
    nChecks++; nFails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end
endmodule